// File: doc/BRIEF.md
# Memory-Mapped Multi-Source Interrupt Controller

This block gathers a set of level-sensitive hardware interrupt lines and a per-source software-pending bit. It drives one interrupt request per CPU. Each source has a mask bit and a target word, which lists the CPUs allowed to receive that source. A source is active when its line is high or its software bit is set, and its mask bit is clear. A CPU's request is raised while any active source names that CPU in its target word.

Software reaches the block over a 32-bit valid/ready register bus. Every access carries the index of the CPU that issues it. The fixed words are:

- an information word with the source count;
- an identity word that returns the caller's CPU index;
- an event word that acknowledges an interrupt.

Reading the event word returns the lowest-numbered active source routed to the caller and masks that source in the same cycle. Software later unmasks the source through the mask-clear bank. The mask bits and the software-pending bits are changed only through separate set and clear banks. In those banks a 1 bit acts and a 0 bit leaves the state alone.

Top module: `intc_core`

## Requirements
- R1: A read of offset 0x0004 returns the source count NUM_SRC in bits [15:0], zero (one die) in bits [27:24], and zero elsewhere.
- R2: A read of offset 0x2000 returns the requesting CPU index (req_cpu) zero-extended to 32 bits.
- R3: A read of offset 0x2004 returns {8'h00 die, 8'h01 type, 16-bit source number}. The source reported is the lowest-numbered one that is routed to the requester and pending (line high or software bit set) and unmasked.
- R4: A read of offset 0x2004 with no such source for the requester returns 32'h0000_0000.
- R5: An event read that reports source n sets the mask bit of n at the same clock edge. From the next cycle on, n no longer contributes to any cpu_irq.
- R6: cpu_irq[c] is high exactly when some source has its line high or its software bit set, has its mask bit clear, and has bit c set in its target word.
- R7: The target word of source n is at 0x3000 + 4*n. Bits [NUM_CPU-1:0] can be read and written, and the upper bits read as zero.
- R8: A 1 in bit b of a write to 0x4000 + 4*w sets the software-pending bit of source 32*w+b. A 1 in the same bit of a write to 0x4080 + 4*w clears it. A read of either address returns that software-pending word.
- R9: A 1 in bit b of a write to 0x4100 + 4*w masks source 32*w+b. A 1 in the same bit of a write to 0x4180 + 4*w unmasks it. A read of either address returns that mask word (1 = masked), with bits above the last source reading 0.
- R10: A 0 bit in a write to any set or clear bank leaves the corresponding state unchanged.
- R11: After reset, every source is masked, no software bit is pending, every target word is zero, and cpu_irq is zero.
- R12: req_ready is always high. Each accepted access produces rsp_valid exactly one cycle later. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Level-sensitive hardware interrupt lines |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_cpu | input | CPU_W | Index of the CPU issuing the access |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| cpu_irq | output | NUM_CPU | Interrupt request per CPU |

## Verification
Each source is first tried on its own. A single line is raised, unmasked and routed to a single CPU. This separates correct routing and source-number encoding from off-by-one and wrong-word faults, and it shows that an event read from a CPU not in the target word returns zero. A fixed set of software-pending sources spread over both bank words is then drained by repeated event reads. This separates lowest-index-first ordering and the automatic masking from any other order. Finally, pseudo-random mixes of line levels, mask words and target words are compared against an arithmetic model of every request output and event word. This covers overlapping targets and the partial last bank word.

// File: rtl/intc_core.sv
module intc_core #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 16,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [CPU_W-1:0]   req_cpu,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_CPU-1:0] cpu_irq
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] mask_q, swp_q, active;
  logic [NUM_CPU-1:0] tgt_q [NUM_SRC];

  assign req_ready = 1'b1;
  assign active    = (irq_in | swp_q) & ~mask_q;

  always_comb begin
    cpu_irq = '0;
    for (int c = 0; c < NUM_CPU; c++)
      for (int n = 0; n < NUM_SRC; n++)
        if (active[n] && tgt_q[n][c]) cpu_irq[c] = 1'b1;
  end

  logic              acc;
  logic              hit_info, hit_id, hit_evt, hit_tgt, hit_bank;
  logic [ADDR_W-1:0] toff;
  logic [SRC_W-1:0]  tidx;
  logic [4:0]        wsel;
  logic [1:0]        bsel;

  assign acc      = req_valid && req_ready;
  assign hit_info = req_addr == ADDR_W'(16'h0004);
  assign hit_id   = req_addr == ADDR_W'(16'h2000);
  assign hit_evt  = req_addr == ADDR_W'(16'h2004);
  assign toff     = req_addr - ADDR_W'(16'h3000);
  assign hit_tgt  = (req_addr[ADDR_W-1:12] == (ADDR_W-12)'(4'h3)) &&
                    (32'(toff[ADDR_W-1:2]) < NUM_SRC);
  assign tidx     = toff[SRC_W+1:2];
  assign hit_bank = req_addr[ADDR_W-1:9] == (ADDR_W-9)'(7'h20);
  assign bsel     = req_addr[8:7];
  assign wsel     = req_addr[6:2];

  logic             found;
  logic [SRC_W-1:0] win;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--)
      if (active[n] && tgt_q[n][req_cpu]) begin
        found = 1'b1;
        win   = SRC_W'(n);
      end
  end

  logic [31:0] sw_word, mk_word, rdata;

  always_comb begin
    sw_word = '0;
    mk_word = '0;
    for (int b = 0; b < 32; b++)
      for (int n = 0; n < NUM_SRC; n++)
        if (n == 32 * int'(wsel) + b) begin
          sw_word[b] = swp_q[n];
          mk_word[b] = mask_q[n];
        end
  end

  always_comb begin
    rdata = '0;
    if (hit_info)      rdata = {4'h0, 4'h0, 8'h00, 16'(NUM_SRC)};
    else if (hit_id)   rdata = 32'(req_cpu);
    else if (hit_evt)  rdata = found ? {8'h00, 8'h01, 16'(win)} : 32'h0;
    else if (hit_tgt)  rdata = 32'(tgt_q[tidx]);
    else if (hit_bank) rdata = bsel[1] ? mk_word : sw_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '1;
      swp_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      for (int n = 0; n < NUM_SRC; n++) tgt_q[n] <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_rdata <= (acc && !req_write) ? rdata : 32'h0;
      if (acc && req_write) begin
        if (hit_tgt) tgt_q[tidx] <= req_wdata[NUM_CPU-1:0];
        if (hit_bank)
          for (int n = 0; n < NUM_SRC; n++)
            if ((n / 32 == int'(wsel)) && req_wdata[n % 32])
              case (bsel)
                2'd0: swp_q[n]  <= 1'b1;
                2'd1: swp_q[n]  <= 1'b0;
                2'd2: mask_q[n] <= 1'b1;
                default: mask_q[n] <= 1'b0;
              endcase
      end
      if (acc && !req_write && hit_evt && found) mask_q[win] <= 1'b1;
    end
  end
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic [31:0]        rsp_rdata,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_CPU-1:0] cpu_irq
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  p_write_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (rsp_rdata == 32'h0));

  p_evt_format_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_addr == ADDR_W'(16'h2004))
      |=> (rsp_rdata[31:24] == 8'h00 &&
           (rsp_rdata[23:16] == 8'h00 || rsp_rdata[23:16] == 8'h01)));

  p_evt_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(req_write) && $past(req_addr) == ADDR_W'(16'h2004) &&
     rsp_rdata[23:16] == 8'h00) |-> (rsp_rdata == 32'h0));

  p_evt_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(req_write) && $past(req_addr) == ADDR_W'(16'h2004) &&
     rsp_rdata[23:16] == 8'h01) |-> mask_q[rsp_rdata[SRC_W-1:0]]);

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> (cpu_irq == '0));
endmodule

bind intc_core intc_core_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .mask_q(mask_q), .cpu_irq(cpu_irq)
);

// File: tb/tb_intc_core.sv
module tb_intc_core;
  localparam int PERIOD = 10;
  localparam int NS = 40;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] hw = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [15:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [1:0]    req_cpu = '0;
  logic          req_ready, rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NC-1:0] cpu_irq;

  intc_core #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(hw), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cpu(req_cpu), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .cpu_irq(cpu_irq)
  );

  always #(PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;
  bit done = 0;
  bit          mmask [NS];
  bit          msw   [NS];
  logic [3:0]  mtgt  [NS];
  logic [31:0] lf = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    return lf;
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] e = '0;
    for (int n = 0; n < NS; n++)
      if ((hw[n] || msw[n]) && !mmask[n]) e |= mtgt[n];
    return e;
  endfunction

  function automatic logic [31:0] exp_word(input bit sel_mask, input int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++)
      if (32 * w + b < NS) v[b] = sel_mask ? mmask[32 * w + b] : msw[32 * w + b];
    return v;
  endfunction

  task automatic bus(input bit wr, input logic [1:0] cpu, input logic [15:0] a,
                     input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cpu = cpu; req_addr = a; req_wdata = d;
    @(negedge clk);
    r = rsp_rdata;
    if (!rsp_valid) chk(1'b0, "R12 rsp_valid", 32'(rsp_valid), 32'h1);
    if (wr && rsp_rdata != 0) chk(1'b0, "R12 write data", rsp_rdata, 32'h0);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] r;
    bus(1'b1, 2'd0, a, d, r);
    if (a >= 16'h3000 && a < 16'h3000 + 16'(4 * NS)) mtgt[(a - 16'h3000) >> 2] = d[3:0];
    if (a[15:9] == 7'h20)
      for (int b = 0; b < 32; b++) begin
        int n = 32 * int'(a[6:2]) + b;
        if (n < NS && d[b])
          case (a[8:7])
            2'd0: msw[n] = 1'b1;
            2'd1: msw[n] = 1'b0;
            2'd2: mmask[n] = 1'b1;
            default: mmask[n] = 1'b0;
          endcase
      end
  endtask

  task automatic rd(input logic [1:0] cpu, input logic [15:0] a, output logic [31:0] r);
    bus(1'b0, cpu, a, 32'h0, r);
  endtask

  task automatic evt(input logic [1:0] cpu, input string req);
    logic [31:0] e = 32'h0, r;
    int k = -1;
    for (int n = NS - 1; n >= 0; n--)
      if ((hw[n] || msw[n]) && !mmask[n] && mtgt[n][cpu]) k = n;
    if (k >= 0) e = {8'h00, 8'h01, 16'(k)};
    rd(cpu, 16'h2004, r);
    chk(r == e, req, r, e);
    if (k >= 0) mmask[k] = 1'b1;
  endtask

  task automatic chk_irq(input string req);
    #1;
    chk(cpu_irq == exp_irq(), req, 32'(cpu_irq), 32'(exp_irq()));
  endtask

  task automatic chk_word(input bit sel_mask, input int w, input string req);
    logic [31:0] r;
    rd(2'd0, 16'h4000 + (sel_mask ? 16'h0100 : 16'h0) + 16'(4 * w), r);
    chk(r == exp_word(sel_mask, w), req, r, exp_word(sel_mask, w));
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int n = 0; n < NS; n++) begin mmask[n] = 1; msw[n] = 0; mtgt[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk_irq("R11 cpu_irq");
    chk_word(1, 0, "R11 mask word0");
    chk_word(1, 1, "R11 mask word1");
    chk_word(0, 0, "R11 sw word0");
    chk_word(0, 1, "R11 sw word1");
    rd(0, 16'h3000 + 16'(4 * (NS - 1)), r); chk(r == 0, "R11 target", r, 0);
    chk(req_ready == 1'b1, "R12 ready", 32'(req_ready), 1);

    // R1, R2
    rd(0, 16'h0004, r); chk(r == 32'(NS), "R1 info", r, 32'(NS));
    for (int c = 0; c < NC; c++) begin
      rd(2'(c), 16'h2000, r); chk(r == 32'(c), "R2 identity", r, 32'(c));
    end

    // R7 target words
    for (int n = 0; n < NS; n++) wr(16'h3000 + 16'(4 * n), 32'hFFFF_FFF0 | 32'(n % 16));
    for (int n = 0; n < NS; n++) begin
      rd(0, 16'h3000 + 16'(4 * n), r);
      chk(r == 32'(n % 16), "R7 target readback", r, 32'(n % 16));
    end

    // Per-source sweep: R3 R4 R5 R6 R9
    for (int n = 0; n < NS; n++) wr(16'h3000 + 16'(4 * n), 32'h0);
    for (int n = 0; n < NS; n++) begin
      wr(16'h3000 + 16'(4 * n), 32'(1 << (n % 4)));
      wr(16'h4180 + 16'(4 * (n / 32)), 32'(1 << (n % 32)));
      @(negedge clk); hw[n] = 1'b1;
      chk_irq("R6 single source");
      evt(2'((n + 1) % 4), "R4 other cpu empty");
      evt(2'(n % 4), "R3 single source event");
      chk_irq("R5 masked after event");
      chk_word(1, n / 32, "R9 mask word after event");
      @(negedge clk); hw[n] = 1'b0;
    end

    // Priority drain: R3 R8 R9 R4
    for (int n = 0; n < NS; n++) wr(16'h3000 + 16'(4 * n), 32'hF);
    wr(16'h4000, 32'h0002_0020);
    wr(16'h4004, 32'h0000_0082);
    chk_word(0, 0, "R8 sw set word0");
    chk_word(0, 1, "R8 sw set word1");
    chk_irq("R6 all masked");
    wr(16'h4180, 32'h0002_0020);
    wr(16'h4184, 32'h0000_0082);
    chk_word(1, 1, "R9 mask clear word1");
    for (int i = 0; i < 4; i++) begin
      chk_irq("R6 drain irq");
      evt(2'd2, "R3 lowest first");
    end
    evt(2'd2, "R4 drained");
    chk_irq("R5 all reported masked");

    // R8 clear, R10 zero bits
    wr(16'h4080, 32'h0000_0020);
    chk_word(0, 0, "R8 sw clear");
    wr(16'h4000, 32'h0); wr(16'h4080, 32'h0); wr(16'h4100, 32'h0); wr(16'h4180, 32'h0);
    chk_word(0, 0, "R10 sw unchanged");
    chk_word(1, 0, "R10 mask unchanged");
    wr(16'h4180, 32'h0002_0000);
    wr(16'h4100, 32'h0);
    chk_word(1, 0, "R10 zero mask-set");
    wr(16'h4080, 32'hFFFF_FFFF); wr(16'h4084, 32'hFFFF_FFFF);

    // Random mixes: R6 R3
    for (int it = 0; it < 30; it++) begin
      wr(16'h4100, 32'hFFFF_FFFF); wr(16'h4104, 32'hFFFF_FFFF);
      wr(16'h4000, rnd() & rnd()); wr(16'h4004, rnd() & rnd());
      wr(16'h4180, rnd()); wr(16'h4184, rnd());
      for (int n = 0; n < NS; n++) wr(16'h3000 + 16'(4 * n), rnd());
      @(negedge clk); hw = {rnd(), rnd()} & {rnd(), rnd()};
      chk_irq("R6 random mix");
      evt(2'(rnd()), "R3 random event");
      chk_irq("R5 random after event");
      evt(2'(rnd()), "R3 random second event");
      chk_word(1, it % 2, "R9 random mask word");
      chk_word(0, it % 2, "R8 random sw word");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule